// File: doc/BRIEF.md
# Bus Activity LED Panel

This block watches the bus of an 8-bit processor: a 16-bit address bus, an 8-bit data bus and the active-low strobes that mark opcode fetch, memory request, I/O request, read and write. It shows that activity on a multiplexed matrix of 16 columns by 8 rows. The panel does not show raw bus levels. For every LED it counts how often the LED's source bit was high on the clocks where the bus carried a valid transfer. The count covers a fixed window of 256 clocks. The result is held as that LED's level, and the LED's on-time within its scan slot follows that level. A line that is busy half the time therefore glows at half brightness.

A 2-bit mode input chooses what the two top rows carry. The choices are the live address, the data bus, and a program-counter register that reloads from the address bus on every opcode fetch. A third row shows the five strobes. Rows are scanned one at a time, and each row holds its slot for 256 clocks while an 8-bit ramp compares against the levels of that row.

Top module: `bus_glow_panel`

## Requirements
- R1: `rst` is synchronous. On the clock after it is sampled high, every column output is 0 and row 0 is selected. The panel stays dark until the first window after reset closes.
- R2: Exactly one bit of `row_o` is high at any time. Rows advance in ascending order 0..7 and then wrap, and each row is held for exactly 256 clocks.
- R3: In a row's 256-clock slot, column c (bit c of `col_o`) is high for exactly L clocks. L (0..255) is the level held for that LED. The ramp starts at 0 on the first clock of the slot.
- R4: A level is the number of sampled clocks in the last 256-clock window on which the LED's source bit was 1, saturating at 255. A source active on every sampled clock gives 255. Sampling on every 2nd clock gives 128, and on every 4th clock gives 64.
- R5: All inputs pass through two flip-flop stages. A clock is sampled only when (`mreq_n` or `iorq_n` is low) and (`rd_n` or `wr_n` is low). Other clocks add nothing, so an idle bus or a memory request with no read or write leaves every LED dark.
- R6: The program-counter register loads the synchronized address on every clock where `m1_n` and `mreq_n` are both low. It holds its value otherwise and is cleared by reset.
- R7: Bit c of rows 0 and 1 maps to column c. The rows follow `mode_i`:
  - Mode 0: row 0 = address, row 1 = data in columns 7..0.
  - Mode 1: row 0 = program counter, row 1 = data.
  - Mode 2: row 0 = address, row 1 = program counter.
  - Mode 3: acts as mode 0.
- R8: Row 2 columns 0..4 show the active strobes in the order fetch, memory request, I/O request, read, write. Row 2 columns 5..15 and rows 3..7 are always dark.
- R9: Levels and the active mode change only when a window closes: 256 clocks after reset is released, then every 256 clocks. `mode_i` is sampled at that instant, so the window that is closing was measured with the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | Address bus |
| data_i | input | 8 | Data bus |
| m1_n | input | 1 | Opcode-fetch qualifier, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mode_i | input | 2 | Display mode select |
| row_o | output | 8 | One-hot row drive, active high |
| col_o | output | 16 | Column drive, active high |

## Verification
The assertions check these properties on every cycle:
- The row drive stays one-hot, and it moves only when the ramp wraps.
- The program-counter register loads only on a qualified fetch and holds otherwise.
- The active mode and the held levels stay frozen between window boundaries.
- The columns are dark on the cycle after reset.

Other behaviour shows only through the bench's scenarios:
- the mapping of each mode to rows and columns;
- the exact on-time that results from a given duty cycle;
- the rule that unqualified clocks add nothing;
- the proof that a mode change waits for the window boundary.

// File: rtl/bus_glow_panel.sv
module bus_glow_panel #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int ROWS  = 8,
  parameter int LVL_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic            m1_n,
  input  logic            mreq_n,
  input  logic            iorq_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [1:0]      mode_i,
  output logic [ROWS-1:0] row_o,
  output logic [AW-1:0]   col_o
);
  localparam int COLS = AW;
  localparam int RW   = $clog2(ROWS);
  localparam int NCTL = 5;
  localparam logic [LVL_W-1:0] TOP  = '1;
  localparam logic [RW-1:0]    LAST = RW'(ROWS - 1);

  logic [AW-1:0]   addr_m, addr_s;
  logic [DW-1:0]   data_m, data_s;
  logic [NCTL-1:0] ctl_m, ctl_s, ctl_raw;

  // strobe order: fetch, memory, io, read, write
  assign ctl_raw = ~{wr_n, rd_n, iorq_n, mreq_n, m1_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_m <= '0;
      addr_s <= '0;
      data_m <= '0;
      data_s <= '0;
      ctl_m  <= '0;
      ctl_s  <= '0;
    end else begin
      addr_m <= addr_i;
      addr_s <= addr_m;
      data_m <= data_i;
      data_s <= data_m;
      ctl_m  <= ctl_raw;
      ctl_s  <= ctl_m;
    end
  end

  logic fetch_s, valid_s;
  assign fetch_s = ctl_s[0] & ctl_s[1];
  assign valid_s = (ctl_s[1] | ctl_s[2]) & (ctl_s[3] | ctl_s[4]);

  logic [AW-1:0] pc_q;
  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (fetch_s) pc_q <= addr_s;
  end

  logic [LVL_W-1:0] win_q;
  logic             win_end;
  logic [1:0]       mode_act;
  assign win_end = (win_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      mode_act <= '0;
    end else begin
      win_q <= win_q + 1'b1;
      if (win_end) mode_act <= mode_i;
    end
  end

  logic [AW-1:0] field_a, field_b;
  always_comb begin
    case (mode_act)
      2'd1: begin
        field_a = pc_q;
        field_b = AW'(data_s);
      end
      2'd2: begin
        field_a = addr_s;
        field_b = pc_q;
      end
      default: begin
        field_a = addr_s;
        field_b = AW'(data_s);
      end
    endcase
  end

  logic [ROWS-1:0][COLS-1:0] src;
  always_comb begin
    src    = '0;
    src[0] = field_a;
    src[1] = field_b;
    src[2] = COLS'(ctl_s);
  end

  logic [ROWS-1:0][COLS-1:0][LVL_W-1:0] cnt, nxt, disp;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        nxt[r][c] = cnt[r][c];
        if (valid_s && src[r][c] && cnt[r][c] != TOP)
          nxt[r][c] = cnt[r][c] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      disp <= '0;
    end else if (win_end) begin
      disp <= nxt;
      cnt  <= '0;
    end else begin
      cnt <= nxt;
    end
  end

  logic [LVL_W-1:0] ramp_q;
  logic [RW-1:0]    row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= '0;
      row_q  <= '0;
    end else begin
      ramp_q <= ramp_q + 1'b1;
      if (ramp_q == TOP) row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
    end
  end

  assign row_o = {{(ROWS-1){1'b0}}, 1'b1} << row_q;

  always_comb begin
    for (int c = 0; c < COLS; c++)
      col_o[c] = ramp_q < disp[row_q][c];
  end

endmodule

// File: rtl/bus_glow_panel_chk.sv
module bus_glow_panel_chk #(
  parameter int AW    = 16,
  parameter int ROWS  = 8,
  parameter int LVL_W = 8
) (
  input logic                               clk,
  input logic                               rst,
  input logic [ROWS-1:0]                    row_o,
  input logic [AW-1:0]                      col_o,
  input logic [LVL_W-1:0]                   ramp_q,
  input logic                               fetch_s,
  input logic [AW-1:0]                      addr_s,
  input logic [AW-1:0]                      pc_q,
  input logic                               win_end,
  input logic [1:0]                         mode_act,
  input logic [ROWS-1:0][AW-1:0][LVL_W-1:0] disp
);
  // R1
  dark_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> col_o == '0);

  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(row_o) == 1);

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_q != '1) |=> $stable(row_o));

  // R6
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_s |=> pc_q == $past(addr_s));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_s |=> $stable(pc_q));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(mode_act));

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(disp));
endmodule

bind bus_glow_panel bus_glow_panel_chk #(.AW(AW), .ROWS(ROWS), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .row_o(row_o), .col_o(col_o), .ramp_q(ramp_q),
  .fetch_s(fetch_s), .addr_s(addr_s), .pc_q(pc_q), .win_end(win_end),
  .mode_act(mode_act), .disp(disp)
);

// File: tb/bus_glow_panel_tb.sv
module bus_glow_panel_tb_top;
  localparam logic [4:0] IDLE  = 5'b11111;
  localparam logic [4:0] RD    = 5'b10101;
  localparam logic [4:0] FETCH = 5'b10100;
  localparam logic [4:0] MQONLY = 5'b11101;
  localparam logic [4:0] IOWR  = 5'b01011;
  localparam int SETTLE = 768;
  localparam int LIMIT  = 190000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [4:0]  ctl_n;
    logic [2:0]  row;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // ctl_n bits: {wr_n, rd_n, iorq_n, mreq_n, m1_n}
  localparam vec_t VECS [0:13] = '{
    '{2'd0, 16'h1234, 8'h5A, RD,     3'd0, 16'h1234, 4'd7},  // R7
    '{2'd0, 16'h1234, 8'h5A, RD,     3'd1, 16'h005A, 4'd7},  // R7
    '{2'd0, 16'h1234, 8'h5A, RD,     3'd2, 16'h000A, 4'd8},  // R8
    '{2'd0, 16'hA5C3, 8'h3E, FETCH,  3'd2, 16'h000B, 4'd8},  // R8
    '{2'd1, 16'h0F0F, 8'h81, RD,     3'd0, 16'hA5C3, 4'd6},  // R6
    '{2'd2, 16'h0F0F, 8'h81, RD,     3'd1, 16'hA5C3, 4'd7},  // R7
    '{2'd2, 16'h0F0F, 8'h81, RD,     3'd0, 16'h0F0F, 4'd7},  // R7
    '{2'd3, 16'h0F0F, 8'h81, RD,     3'd1, 16'h0081, 4'd7},  // R7
    '{2'd0, 16'hFFFF, 8'hFF, IDLE,   3'd0, 16'h0000, 4'd5},  // R5
    '{2'd0, 16'hFFFF, 8'hFF, MQONLY, 3'd0, 16'h0000, 4'd5},  // R5
    '{2'd0, 16'hFFFF, 8'hFF, MQONLY, 3'd2, 16'h0000, 4'd5},  // R5
    '{2'd0, 16'h00C0, 8'h77, IOWR,   3'd1, 16'h0077, 4'd5},  // R5
    '{2'd0, 16'h00C0, 8'h77, IOWR,   3'd2, 16'h0014, 4'd8},  // R8
    '{2'd0, 16'h00C0, 8'h77, IOWR,   3'd3, 16'h0000, 4'd8}   // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [4:0]  ctl_n = IDLE;
  logic [1:0]  mode = '0;
  logic [7:0]  row_o;
  logic [15:0] col_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int prev_idx, run, errs, trans, idx;

  always #2 clk = ~clk;

  bus_glow_panel dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .data_i(data),
    .m1_n(ctl_n[0]), .mreq_n(ctl_n[1]), .iorq_n(ctl_n[2]),
    .rd_n(ctl_n[3]), .wr_n(ctl_n[4]), .mode_i(mode),
    .row_o(row_o), .col_o(col_o)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      if (cyc == LIMIT) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        report();
        $finish;
      end
    end
  end

  task automatic enter_row(input int r);
    while (row_o[r] !== 1'b0) @(negedge clk);
    while (row_o[r] !== 1'b1) @(negedge clk);
  endtask

  // R3 R4: drive a read on every period-th clock, measure row 0 column 0 on-time
  task automatic duty_case(input int period, input int exp_on, input string tag);
    int on_cnt = 0;
    int seen = 0;
    logic prev = 1'b1;
    for (int k = 0; k < 6000 && seen < 256; k++) begin
      @(negedge clk);
      if (k >= SETTLE) begin
        if (seen > 0) begin
          if (col_o[0]) on_cnt++;
          seen++;
        end else if (!prev && row_o[0]) begin
          if (col_o[0]) on_cnt++;
          seen = 1;
        end
      end
      prev = row_o[0];
      ctl_n = (k % period == 0) ? RD : IDLE;
    end
    check(tag, on_cnt, exp_on);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: dark and row 0 while reset held
    check("R1 columns in reset", col_o, 16'h0);
    check("R1 row in reset", row_o, 8'h01);

    // R9: first window closes 256 clocks after release, measured with old mode
    mode  = 2'd2;
    data  = 8'h01;
    ctl_n = RD;
    rst   = 1'b0;
    repeat (255) @(negedge clk);
    check("R9 dark before first window closes", col_o, 16'h0);
    @(negedge clk);
    check("R9 row 1 slot begins", row_o, 8'h02);
    check("R9 window measured with previous mode", col_o, 16'h0001);

    // R2: row order and slot length
    prev_idx = -1; run = 0; errs = 0; trans = 0;
    for (int k = 0; k < 2600; k++) begin
      @(negedge clk);
      if ($countones(row_o) != 1) errs++;
      else begin
        idx = 0;
        for (int b = 0; b < 8; b++) if (row_o[b]) idx = b;
        if (idx != prev_idx) begin
          if (prev_idx >= 0) begin
            if (idx != (prev_idx + 1) % 8) errs++;
            if (trans > 0 && run != 256) errs++;
            trans++;
          end
          prev_idx = idx;
          run = 1;
        end else run++;
      end
    end
    check("R2 scan order and slot length errors", errs, 0);
    check("R2 full cycle of rows seen", trans >= 8, 1);

    // R5 R6 R7 R8: table walk
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      mode  = VECS[i].mode;
      addr  = VECS[i].addr;
      data  = VECS[i].data;
      ctl_n = VECS[i].ctl_n;
      repeat (SETTLE) @(negedge clk);
      enter_row(int'(VECS[i].row));
      repeat (4) @(negedge clk);
      check($sformatf("R%0d vector %0d row %0d", VECS[i].req, i, VECS[i].row),
            col_o, VECS[i].exp);
    end

    // R3 R4: brightness follows duty cycle
    mode = 2'd0;
    addr = 16'h0001;
    data = 8'h00;
    duty_case(1, 255, "R3 steady activity on-time");
    duty_case(2, 128, "R4 half duty on-time");
    duty_case(4, 64, "R4 quarter duty on-time");

    // R1: reset mid-run blanks a lit panel
    @(negedge clk);
    ctl_n = RD;
    rst = 1'b1;
    @(negedge clk);
    check("R1 columns after reset", col_o, 16'h0);
    check("R1 row after reset", row_o, 8'h01);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    check("R1 dark within first window", col_o, 16'h0);

    done = 1;
    report();
    $finish;
  end
endmodule